// File: doc/BRIEF.md
# Call/Return Control-Flow Monitor

This block sits beside a pipelined processor and watches each instruction as it commits. It decodes the instruction register to find calls and returns, and it keeps the index of the function that is currently running. Before the program starts, software loads a small table into the block. The table holds the entry address of each function, the set of functions that each function may call, and the set of functions that each function may return into.

Every call and return is checked against this table. A return is also checked against a stack of caller indices held inside the block. When a check fails, the state machine enters a trap state. That state is reported as a sticky violation flag, and a one-cycle interrupt request is raised with it.

Checks take a variable number of cycles. The function table is searched one entry per cycle, which keeps the logic to a single address comparator. A stall output lets the processor wait for a check, and a mode input selects how strictly it waits:
- In guarded (prevention) mode the stall is held for the whole time a check is pending.
- In watch (detection) mode only a second call or return is held back. Ordinary instructions keep committing.

Top module: `ctrlflow_monitor`

## Requirements
- R1: After reset, `fn_o` is 0, `invalid_o` is low, `stall_o` is low and `irq_o` is low.
- R2: An instruction whose bits [31:26] equal 6'h03 is a call, and one whose bits [31:26] equal 6'h04 is a return. Any other committed instruction leaves `fn_o` and `invalid_o` unchanged.
- R3: The target of a call is `pc_i + instr_i[15:0]`, taken modulo 2^16. The table is searched from index 0 upward, one entry per cycle. If the first matching entry k is permitted for the current function, `fn_o` becomes k. This happens at the clock edge k+1 cycles after the edge that accepts the call.
- R4: A call goes to the trap state if it is not permitted from the current function, or if its target matches no entry. Bit j of a function's call row permits a call to function j. A call whose target matches no entry is trapped after all NF entries have been searched.
- R5: A return pops the caller index c from the stack. It moves `fn_o` to c one cycle after it is accepted, but only if bit c of the current function's return row is set. If that bit is clear, the return is trapped.
- R6: A return with an empty stack is trapped, and so is a permitted call made while the stack already holds 16 entries.
- R7: The trap state shows `fn_o` = NF (8) and `invalid_o` high. It ignores further calls and returns and keeps stall low. Only reset or a `clr_i` pulse leaves it, and either one returns to function 0 with an empty stack.
- R8: `irq_o` is high for exactly one cycle: the first cycle in which `invalid_o` is high.
- R9: With `prevent_i` high, `stall_o` is high in every cycle in which a check is pending, whether or not `commit_i` is asserted.
- R10: With `prevent_i` low, `stall_o` rises only while a check is pending and a call or return is presented. Other instructions commit without a stall.
- R11: An instruction presented while `stall_o` is high is not taken. It is taken exactly once, in the first cycle in which it is presented with `stall_o` low.
- R12: A `clr_i` pulse takes priority over a check that resolves in the same cycle. The block returns to function 0 with no violation and no interrupt request.
- R13: A table write happens when `cfg_we_i` is high. `cfg_sel_i` chooses what is written: 0 writes the entry address, 1 writes the call row and 2 writes the return row. The entry written is the one for function `cfg_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| commit_i | input | 1 | An instruction is presented for commit |
| instr_i | input | 32 | Instruction register of the presented instruction |
| pc_i | input | 16 | Address of the presented instruction |
| prevent_i | input | 1 | 1 selects guarded mode, 0 selects watch mode |
| clr_i | input | 1 | Pulse that leaves the trap state and empties the stack |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_sel_i | input | 2 | Table field select: entry address, call row or return row |
| cfg_idx_i | input | 3 | Function index of the table write |
| cfg_data_i | input | 16 | Table write data; rows use the low NF bits |
| stall_o | output | 1 | Asks the processor to hold its commit |
| invalid_o | output | 1 | Sticky control-flow violation |
| irq_o | output | 1 | One-cycle non-maskable interrupt request |
| fn_o | output | 4 | Current function index; NF means the trap state |

## Verification
A `clr_i` pulse can arrive in the same cycle as a pending check that would trap. The bench provokes this by issuing a call to a function that is not permitted and then timing the clear pulse to land in the final search cycle. It then judges at the ports that `fn_o` returns to 0 and that `invalid_o`, `irq_o` and `stall_o` all stay low.

A second overlap comes from watch mode. The bench presents an ordinary instruction and then a return while a call is still being checked. It expects the first to pass with no stall and the second to be held for exactly the remaining search cycles. The return must be taken only once, which shows up as a clean return to function 0 instead of an underflow trap.

// File: rtl/ctrlflow_monitor.sv
module ctrlflow_monitor #(
  parameter int AW = 16,
  parameter int IW = 32,
  parameter int NF = 8,
  parameter int DEPTH = 16,
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_CALL = 6'h03,
  parameter logic [OPW-1:0] OP_RET = 6'h04
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     commit_i,
  input  logic [IW-1:0]            instr_i,
  input  logic [AW-1:0]            pc_i,
  input  logic                     prevent_i,
  input  logic                     clr_i,
  input  logic                     cfg_we_i,
  input  logic [1:0]               cfg_sel_i,
  input  logic [$clog2(NF)-1:0]    cfg_idx_i,
  input  logic [AW-1:0]            cfg_data_i,
  output logic                     stall_o,
  output logic                     invalid_o,
  output logic                     irq_o,
  output logic [$clog2(NF+1)-1:0]  fn_o
);
  localparam int FW = $clog2(NF+1);
  localparam int IX = $clog2(NF);
  localparam int SW = $clog2(DEPTH+1);
  localparam int DW = $clog2(DEPTH);
  localparam logic [FW-1:0] TRAP = FW'(NF);

  logic [AW-1:0] entry   [NF];
  logic [NF-1:0] call_ok [NF];
  logic [NF-1:0] ret_ok  [NF];
  logic [IX-1:0] stk     [DEPTH];
  logic [SW-1:0] sp;
  logic [FW-1:0] fn;
  logic [AW-1:0] tgt;
  logic [IX-1:0] srch;
  logic          busy, pend_call, irq;
  logic          ok, bad;

  wire [OPW-1:0] op      = instr_i[IW-1 -: OPW];
  wire           is_call = (op == OP_CALL);
  wire           is_ret  = (op == OP_RET);
  wire           invalid = (fn == TRAP);
  wire [IX-1:0]  cur     = fn[IX-1:0];
  wire [IX-1:0]  caller  = stk[DW'(sp - 1'b1)];
  wire           hit     = (entry[srch] == tgt);
  wire           full    = (sp == SW'(DEPTH));
  wire           empty   = (sp == '0);
  wire           take    = commit_i && (is_call || is_ret) && !busy && !invalid;

  logic unused_bits;
  assign unused_bits = ^instr_i[IW-OPW-1:AW];

  assign stall_o   = busy && (prevent_i || (commit_i && (is_call || is_ret)));
  assign invalid_o = invalid;
  assign irq_o     = irq;
  assign fn_o      = fn;

  always_comb begin
    ok  = 1'b0;
    bad = 1'b0;
    if (busy) begin
      if (pend_call) begin
        if (hit) begin
          if (call_ok[cur][srch] && !full) ok = 1'b1;
          else bad = 1'b1;
        end else if (srch == IX'(NF-1)) begin
          bad = 1'b1;
        end
      end else begin
        if (!empty && ret_ok[cur][caller]) ok = 1'b1;
        else bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn        <= '0;
      sp        <= '0;
      tgt       <= '0;
      srch      <= '0;
      busy      <= 1'b0;
      pend_call <= 1'b0;
      irq       <= 1'b0;
      for (int i = 0; i < NF; i++) begin
        entry[i]   <= '0;
        call_ok[i] <= '0;
        ret_ok[i]  <= '0;
      end
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      if (cfg_we_i) begin
        case (cfg_sel_i)
          2'd0:    entry[cfg_idx_i]   <= cfg_data_i;
          2'd1:    call_ok[cfg_idx_i] <= cfg_data_i[NF-1:0];
          2'd2:    ret_ok[cfg_idx_i]  <= cfg_data_i[NF-1:0];
          default: ;
        endcase
      end
      irq <= 1'b0;
      if (clr_i) begin
        fn   <= '0;
        sp   <= '0;
        busy <= 1'b0;
      end else if (bad) begin
        fn   <= TRAP;
        busy <= 1'b0;
        irq  <= 1'b1;
      end else if (ok) begin
        busy <= 1'b0;
        if (pend_call) begin
          stk[sp[DW-1:0]] <= cur;
          sp <= sp + 1'b1;
          fn <= FW'(srch);
        end else begin
          sp <= sp - 1'b1;
          fn <= FW'(caller);
        end
      end else if (busy) begin
        srch <= srch + 1'b1;
      end else if (take) begin
        busy      <= 1'b1;
        pend_call <= is_call;
        tgt       <= pc_i + instr_i[AW-1:0];
        srch      <= '0;
      end
    end
  end

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalid_o && !clr_i) |=> invalid_o);
  p_irq_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (invalid_o && !$past(invalid_o)));
  p_irq_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_stack_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp <= SW'(DEPTH));
  p_idle_nostall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !stall_o);
  p_clear_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (fn_o == '0 && !invalid_o && !irq_o));
endmodule

// File: tb/sim_ctrlflow_monitor.sv
`timescale 1ns/1ps
module sim_ctrlflow_monitor;
  logic clk = 0, rst_n = 0, commit = 0, prevent = 1, clr = 0, cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [2:0] cfg_idx = 0;
  logic [15:0] cfg_data = 0, pc = 0;
  logic [31:0] ir = 0;
  logic stall, inv, irq;
  logic [3:0] fn;
  int checks = 0, errors = 0;
  int qfn[$];
  bit qinv[$];
  string qtag[$];

  always #2.5 clk = ~clk;

  ctrlflow_monitor u0 (.clk_i(clk), .rst_ni(rst_n), .commit_i(commit), .instr_i(ir),
    .pc_i(pc), .prevent_i(prevent), .clr_i(clr), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data), .stall_o(stall), .invalid_o(inv),
    .irq_o(irq), .fn_o(fn));

  function automatic logic [31:0] mk_call(input logic [15:0] off);
    return {6'h03, 10'h0, off};
  endfunction
  function automatic logic [31:0] mk_ret();
    return {6'h04, 26'h0};
  endfunction
  function automatic logic [15:0] ent(input int i);
    return 16'(16'h1000 + i * 256);
  endfunction

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_state(input int efn, input bit einv, input string tag);
    qfn.push_back(efn); qinv.push_back(einv); qtag.push_back(tag);
  endtask

  initial forever begin
    @(negedge clk); #2;
    while (qfn.size() > 0) begin
      int efn; bit einv; string t;
      efn = qfn.pop_front(); einv = qinv.pop_front(); t = qtag.pop_front();
      checks++;
      if (fn !== 4'(efn) || inv !== einv) begin
        errors++;
        $display("FAIL %s: actual fn=%0d inv=%0b expected fn=%0d inv=%0b", t, fn, inv, efn, einv);
      end
    end
  end

  task automatic wr(input logic [1:0] s, input int idx, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_idx = 3'(idx); cfg_data = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic issue(input logic [31:0] i, input logic [15:0] p, output int st);
    @(negedge clk); commit = 1; ir = i; pc = p; st = 0;
    forever begin
      #1;
      if (!stall) begin @(negedge clk); break; end
      @(negedge clk); st++;
    end
    commit = 0; ir = 0;
  endtask

  task automatic op_wait(input logic [31:0] i, input logic [15:0] p, input int k, output int cnt);
    int st;
    issue(i, p, st);
    cnt = 0;
    repeat (k + 1) begin
      #1; if (stall) cnt++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c, st;
    repeat (3) @(negedge clk);
    chk(fn == 0 && !inv && !stall && !irq, "R1 reset state", {fn, inv, stall, irq}, 0);
    rst_n = 1;
    for (int i = 0; i < 8; i++) wr(2'd0, i, ent(i));
    wr(2'd1, 0, 16'h00CE); wr(2'd1, 1, 16'h0004); wr(2'd1, 3, 16'h0008);
    wr(2'd2, 1, 16'h0001); wr(2'd2, 2, 16'h0003); wr(2'd2, 3, 16'h0009);
    wr(2'd2, 7, 16'h0001);

    op_wait(mk_call(ent(1)), 16'h0000, 1, c);
    chk(c == 2, "R9 prevention stall length", c, 2);
    expect_state(1, 0, "R3 call to fn1");

    issue({6'h00, 26'h1000}, 16'h0040, st);
    issue({6'h05, 26'h1200}, 16'h0044, st);
    repeat (2) @(negedge clk);
    expect_state(1, 0, "R2 non-control opcodes ignored");

    op_wait(mk_call(16'h2200), 16'hF000, 2, c);
    expect_state(2, 0, "R3 wrapped target reaches fn2");
    op_wait(mk_ret(), 16'h1204, 0, c);
    chk(c == 1, "R9 return check stall", c, 1);
    expect_state(1, 0, "R5 return into fn1");
    op_wait(mk_ret(), 16'h1104, 0, c);
    expect_state(0, 0, "R5 return into fn0");

    op_wait(mk_call(ent(3)), 16'h0000, 3, c);
    for (int n = 0; n < 15; n++) op_wait(mk_call(ent(3)), 16'h0000, 3, c);
    expect_state(3, 0, "R6 sixteen nested calls accepted");
    op_wait(mk_call(ent(3)), 16'h0000, 3, c);
    #1;
    chk(irq == 1, "R8 irq raised on overflow", irq, 1);
    expect_state(8, 1, "R6 stack overflow trapped");
    @(negedge clk); #1;
    chk(irq == 0 && inv == 1, "R8 irq lasts one cycle", irq, 0);

    issue(mk_ret(), 16'h1300, st);
    chk(st == 0, "R7 no stall in trap state", st, 0);
    repeat (2) @(negedge clk);
    expect_state(8, 1, "R7 trap is sticky");
    pulse_clr();
    expect_state(0, 0, "R7 clear leaves trap");

    op_wait(mk_ret(), 16'h0010, 0, c);
    expect_state(8, 1, "R6 return underflow trapped");
    pulse_clr();

    op_wait(mk_call(ent(4)), 16'h0000, 4, c);
    expect_state(8, 1, "R4 call not permitted");
    pulse_clr();
    op_wait(mk_call(16'h1234), 16'h0000, 7, c);
    expect_state(8, 1, "R4 unknown target");
    pulse_clr();

    op_wait(mk_call(ent(6)), 16'h0000, 6, c);
    expect_state(6, 0, "R13 loaded row permits fn6");
    op_wait(mk_ret(), 16'h1600, 0, c);
    expect_state(8, 1, "R5 return not permitted");
    pulse_clr();

    prevent = 0;
    @(negedge clk); commit = 1; ir = mk_call(ent(3)); pc = 0;
    #1; chk(stall == 0, "R10 idle call no stall", stall, 0);
    @(negedge clk); ir = {6'h00, 26'h0};
    #1; chk(stall == 0, "R10 plain instruction passes", stall, 0);
    @(negedge clk); ir = mk_ret(); c = 0;
    forever begin
      #1;
      if (!stall) begin @(negedge clk); break; end
      @(negedge clk); c++;
    end
    commit = 0;
    chk(c == 3, "R10 control held while pending", c, 3);
    @(negedge clk);
    expect_state(0, 0, "R11 held return taken once");

    prevent = 1;
    issue(mk_call(ent(4)), 16'h0000, st);
    repeat (4) @(negedge clk);
    clr = 1;
    @(negedge clk); clr = 0;
    #1;
    chk(irq == 0 && stall == 0, "R12 clear beats trap", {irq, stall}, 0);
    expect_state(0, 0, "R12 clear beats trap state");
    op_wait(mk_call(ent(7)), 16'h0000, 7, c);
    expect_state(7, 0, "R3 call to last entry");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule